// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor countdown timer of a local interrupt controller. Software sets it up through a small synchronous register port. One register holds the timer entry: an 8-bit interrupt vector, a mask bit and a one-shot/periodic select. A second register selects a power-of-two bus-clock prescaler. A third holds the initial count, and a fourth gives a read-only view of the running 32-bit current count.

Writing the initial count loads the current count and restarts the prescaler. The counter then steps down once per prescaled tick. The step that takes it from one to zero is the expiry. In one-shot mode the counter stops at zero. In periodic mode the expiry reloads the counter from the initial count.

When an expiry occurs and the entry is unmasked, the block raises a sticky interrupt request that carries the programmed vector. The request stays up until the acknowledge input clears it. A masked entry only blocks delivery and does not stop the counter. Software can read the current count at any moment to measure elapsed bus clocks.

Top module: `lict_timer`

## Requirements
- R1: After reset the entry reads 0x100 (mask set, vector 0, one-shot), the divide code, initial count and current count read 0, and irq_req is low.
- R2: Register select 0 is the entry: vector in bits 7:0, mask in bit 8, periodic select in bit 9 (1 = periodic). Select 1 is the divide code in bits 2:0, giving a divisor of 2 to the power of the code, so code 4 divides by 16. Select 2 is the initial count and select 3 is the current count. rd_data follows reg_sel in the same cycle, and unused bits read 0.
- R3: A write to the initial count loads the written value into the current count at that clock edge and restarts the prescaler. Writing 0 leaves the timer stopped and raises no interrupt.
- R4: With divide code c and initial count N, the current count drops by one every 2^c cycles. The expiry happens at the N·2^c-th clock edge after the write edge.
- R5: In one-shot mode the current count is 0 after the expiry and stays 0 until the initial count is written again.
- R6: In periodic mode the expiry reloads the current count from the initial count in the same edge. The counter runs on with a period of N·2^c cycles and reads back only values from N down to 1.
- R7: An unmasked expiry sets irq_req at the expiry edge, and irq_vec shows the entry's vector.
- R8: While the mask bit is set, an expiry does not set irq_req, but the counter keeps counting and reloading.
- R9: irq_req stays high until an edge with irq_ack high clears it. If an expiry coincides with the acknowledge, the request stays set. Expiries that occur while the request is pending are not queued, so one acknowledge clears all of them.
- R10: Writes to the current-count select are ignored: the count continues unchanged and the initial count is not altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for reg_sel |
| irq_ack | input | 1 | Acknowledge of the interrupt request |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vec | output | 8 | Vector presented with the request |

## Verification
The bench aims at the exact expiry edge for several divide codes. A design with an off-by-one in the prescaler or in the zero detection would raise the request one tick early or late, or show the wrong count at a random mid-point. It drives an acknowledge in the very cycle of a periodic expiry, where a design that lets the clear win would lose an interrupt. It lets two expiries pass without an acknowledge, where a queueing design would re-assert the request after the first acknowledge. Masked periodic runs, a zero initial count and writes to the current-count select show whether the mask stops the counter, whether zero starts a spurious expiry, and whether the read-only count can be corrupted.

// File: rtl/lict_pkg.sv
package lict_pkg;

   localparam int VEC_W = 8;

   typedef enum logic [1:0] {
      SEL_ENTRY   = 2'd0,
      SEL_DIVIDE  = 2'd1,
      SEL_INIT    = 2'd2,
      SEL_CURRENT = 2'd3
   } lict_sel_e;

   typedef struct packed {
      logic             periodic;
      logic             masked;
      logic [VEC_W-1:0] vector;
   } lict_entry_t;

   localparam int ENTRY_W = $bits(lict_entry_t);

   localparam lict_entry_t ENTRY_RESET = '{periodic: 1'b0, masked: 1'b1, vector: '0};

endpackage

// File: rtl/lict_regs.sv
module lict_regs
   import lict_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int DIVSEL_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          reg_sel,
   input  logic [CNT_W-1:0]    wr_data,
   input  logic [CNT_W-1:0]    cur_cnt,
   output lict_entry_t         entry,
   output logic [DIVSEL_W-1:0] div_code,
   output logic [CNT_W-1:0]    init_cnt,
   output logic                init_load,
   output logic [CNT_W-1:0]    rd_data
);

   lict_sel_e sel;
   assign sel = lict_sel_e'(reg_sel);

   assign init_load = wr_en && (sel == SEL_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry    <= ENTRY_RESET;
         div_code <= '0;
         init_cnt <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_ENTRY:  entry    <= lict_entry_t'(wr_data[ENTRY_W-1:0]);
            SEL_DIVIDE: div_code <= wr_data[DIVSEL_W-1:0];
            SEL_INIT:   init_cnt <= wr_data;
            default:    ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_ENTRY:   rd_data[ENTRY_W-1:0]  = entry;
         SEL_DIVIDE:  rd_data[DIVSEL_W-1:0] = div_code;
         SEL_INIT:    rd_data               = init_cnt;
         SEL_CURRENT: rd_data               = cur_cnt;
         default:     rd_data               = '0;
      endcase
   end

endmodule

// File: rtl/lict_prescale.sv
module lict_prescale #(
   parameter int DIVSEL_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic [DIVSEL_W-1:0] div_code,
   output logic                tick
);

   localparam int PRE_W = (1 << DIVSEL_W) - 1;

   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] low_mask;

   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign low_mask[i] = (div_code > DIVSEL_W'(i));
   end

   assign tick = &(pcnt | ~low_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
   end

endmodule

// File: rtl/lict_countdown.sv
module lict_countdown #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] init_cnt,
   input  logic             periodic,
   input  logic             tick,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             expire
);

   logic at_one;
   logic running;

   assign at_one  = (cur_cnt == CNT_W'(1));
   assign running = (cur_cnt != '0);
   assign expire  = !load && tick && at_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_cnt <= '0;
      end else if (load) begin
         cur_cnt <= load_val;
      end else if (tick && running) begin
         if (at_one) cur_cnt <= periodic ? init_cnt : '0;
         else        cur_cnt <= cur_cnt - 1'b1;
      end
   end

endmodule

// File: rtl/lict_irq.sv
module lict_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic masked,
   input  logic ack,
   output logic req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                req <= 1'b0;
      else if (expire && !masked) req <= 1'b1;
      else if (ack)              req <= 1'b0;
   end

endmodule

// File: rtl/lict_timer.sv
module lict_timer
   import lict_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int DIVSEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       reg_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec
);

   if (CNT_W < 16 || CNT_W > 64) begin : g_bad_cnt_w
      $error("lict_timer: CNT_W must lie in 16..64");
   end
   if (DIVSEL_W < 3 || DIVSEL_W > 5) begin : g_bad_divsel_w
      $error("lict_timer: DIVSEL_W must lie in 3..5 so that divide-by-16 exists");
   end

   lict_entry_t         entry;
   logic [DIVSEL_W-1:0] div_code;
   logic [CNT_W-1:0]    init_cnt;
   logic                init_load;
   logic [CNT_W-1:0]    cur_cnt;
   logic                tick;
   logic                expire;

   lict_regs #(.CNT_W(CNT_W), .DIVSEL_W(DIVSEL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .reg_sel   (reg_sel),
      .wr_data   (wr_data),
      .cur_cnt   (cur_cnt),
      .entry     (entry),
      .div_code  (div_code),
      .init_cnt  (init_cnt),
      .init_load (init_load),
      .rd_data   (rd_data)
   );

   lict_prescale #(.DIVSEL_W(DIVSEL_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (init_load),
      .div_code (div_code),
      .tick     (tick)
   );

   lict_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (init_load),
      .load_val (wr_data),
      .init_cnt (init_cnt),
      .periodic (entry.periodic),
      .tick     (tick),
      .cur_cnt  (cur_cnt),
      .expire   (expire)
   );

   lict_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .masked (entry.masked),
      .ack    (irq_ack),
      .req    (irq_req)
   );

   assign irq_vec = entry.vector;

endmodule

// File: rtl/lict_timer_chk.sv
module lict_timer_chk
   import lict_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       reg_sel,
   input logic [CNT_W-1:0] wr_data,
   input logic             irq_ack,
   input logic             irq_req,
   input logic [CNT_W-1:0] cur_cnt,
   input logic             expire,
   input logic             masked
);

   logic ic_wr;
   assign ic_wr = wr_en && (reg_sel == SEL_INIT);

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ic_wr |=> (cur_cnt == $past(wr_data)));                                   // R3

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ic_wr && cur_cnt > CNT_W'(1)) |=>
         (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - 1'b1));     // R4

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ic_wr && cur_cnt == '0) |=> (cur_cnt == '0));                          // R5

   AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (masked && !irq_req) |=> !irq_req);                                       // R8

   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> irq_req);                                       // R9

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !expire) |=> !irq_req);                                       // R9

   AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !masked) |=> irq_req);                                         // R7

endmodule

bind lict_timer lict_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .reg_sel (reg_sel),
   .wr_data (wr_data),
   .irq_ack (irq_ack),
   .irq_req (irq_req),
   .cur_cnt (cur_cnt),
   .expire  (expire),
   .masked  (entry.masked)
);

// File: tb/lict_timer_tb.sv
module lict_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [7:0]  irq_vec;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   lict_timer u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .reg_sel (reg_sel),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq_ack (irq_ack),
      .irq_req (irq_req),
      .irq_vec (irq_vec)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] exp_cur(input int n, input int code, input int k);
      return 32'(n - (k >> code));
   endfunction

   function automatic int exp_span(input int n, input int code);
      return n << code;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; reg_sel = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_sel = a;
      #1;
      d = rd_data;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic waitc(input int k);
      repeat (k) @(negedge clk);
   endtask

   logic [31:0] v;

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 entry", v, 32'h100);
      rd(2'd1, v); chk("R1 divide", v, 0);
      rd(2'd2, v); chk("R1 init", v, 0);
      rd(2'd3, v); chk("R1 current", v, 0);
      chk("R1 irq", irq_req, 0);

      // R2 entry readback, R5/R7 one-shot expiry
      wr(2'd0, 32'h05A);
      rd(2'd0, v); chk("R2 entry readback", v, 32'h05A);
      wr(2'd2, 5);
      rd(2'd3, v); chk("R3 load", v, 5);
      waitc(4);
      rd(2'd3, v); chk("R4 count div1", v, 1);
      chk("R7 no early irq", irq_req, 0);
      waitc(1);
      rd(2'd3, v); chk("R5 stop at zero", v, 0);
      chk("R7 irq at expiry", irq_req, 1);
      chk("R7 vector", irq_vec, 8'h5A);
      waitc(10);
      rd(2'd3, v); chk("R5 stays zero", v, 0);
      chk("R9 irq held", irq_req, 1);
      ack();
      chk("R9 ack clears", irq_req, 0);

      // R3 zero initial count
      wr(2'd2, 0);
      waitc(20);
      rd(2'd3, v); chk("R3 zero stays stopped", v, 0);
      chk("R3 zero no irq", irq_req, 0);

      // R4 divide by 16
      wr(2'd1, 4);
      rd(2'd1, v); chk("R2 divide readback", v, 4);
      wr(2'd2, 3);
      waitc(exp_span(3, 4) - 1);
      rd(2'd3, v); chk("R4 div16 before expiry", v, 1);
      chk("R4 div16 no early irq", irq_req, 0);
      waitc(1);
      chk("R4 div16 expiry edge", irq_req, 1);
      ack();

      // R6 periodic, R9 no queueing
      wr(2'd0, 32'h2A5);
      wr(2'd1, 0);
      wr(2'd2, 4);
      waitc(4);
      chk("R6 irq", irq_req, 1);
      chk("R7 vector periodic", irq_vec, 8'hA5);
      rd(2'd3, v); chk("R6 reload", v, 4);
      waitc(2);
      rd(2'd3, v); chk("R6 continues", v, 2);
      ack();
      chk("R9 cleared", irq_req, 0);
      waitc(1);
      chk("R6 second expiry", irq_req, 1);
      waitc(4);
      ack();
      chk("R9 not queued", irq_req, 0);
      waitc(1);
      chk("R9 stays clear", irq_req, 0);
      rd(2'd3, v); chk("R6 period", v, 2);

      // R8 masked periodic keeps running
      wr(2'd0, 32'h3A5);
      wr(2'd2, 4);
      waitc(8);
      chk("R8 masked no irq", irq_req, 0);
      rd(2'd3, v); chk("R8 reload while masked", v, 4);
      waitc(2);
      rd(2'd3, v); chk("R8 counting while masked", v, 2);

      // R9 ack coincident with expiry
      wr(2'd0, 32'h2A5);
      wr(2'd2, 3);
      waitc(2);
      ack();
      chk("R9 expiry beats ack", irq_req, 1);
      rd(2'd3, v); chk("R6 reload on coincident", v, 3);
      ack();
      chk("R9 later ack clears", irq_req, 0);

      // R10 current count not writable
      wr(2'd2, 10);
      wr(2'd3, 32'h55);
      rd(2'd3, v); chk("R10 current ignored", v, 9);
      rd(2'd2, v); chk("R10 init untouched", v, 10);

      wr(2'd2, 0);
      ack();
      rd(2'd3, v); chk("R3 stop by zero write", v, 0);

      // R4/R5/R7 random one-shot runs
      for (int it = 0; it < 30; it++) begin
         int n    = $urandom_range(1, 20);
         int code = $urandom_range(0, 4);
         int span = exp_span(n, code);
         int k    = $urandom_range(0, span - 1);
         logic [7:0] vec = 8'($urandom);
         wr(2'd0, {24'h0, vec});
         wr(2'd1, 32'(code));
         wr(2'd2, 32'(n));
         waitc(k);
         rd(2'd3, v); chk("R4 random mid count", v, exp_cur(n, code, k));
         chk("R7 random no early irq", irq_req, 0);
         waitc(span - k);
         rd(2'd3, v); chk("R5 random zero", v, 0);
         chk("R7 random irq", irq_req, 1);
         chk("R7 random vector", irq_vec, vec);
         ack();
         chk("R9 random ack", irq_req, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule